// File: doc/BRIEF.md
# Inter-core doorbell distributor

This block carries hypervisor-level doorbell messages between the cores of a multi-core system. Every core owns a send port. When that core executes a message-send operation, the port turns the target number in the operand into a one-cycle, one-hot request vector with one bit per core. A system-level merge stage ORs bit t of every core's request vector. The result is delivered to core t.

Each core keeps a sticky pending flag. An incoming message sets it. A local message-clear, or acceptance of the doorbell interrupt, clears it. The interrupt request is the pending flag gated by that core's hypervisor external-interrupt enable. A message-sync operation is accepted and does nothing. Only the hypervisor doorbell level exists. Interrupt vectoring and instruction decode are handled elsewhere.

Pending and interrupt outputs are registered. A send that is sampled at one rising edge is registered as a request at that edge. It appears on the target's pending output after the next rising edge.

Top module: `doorbell_hub`

## Requirements
- R1: While reset is high, and after it, every pending and interrupt output is 0 until a message arrives.
- R2: A send from any core with target t (0 <= t < NUM_CORES) sampled at edge k makes pending[t] read 1 after edge k+1 and not before.
- R3: A send whose target field (low TGT_W bits of the operand) is NUM_CORES or more changes no pending bit.
- R4: A core may target itself, with the same latency as in R2.
- R5: Sends from several cores in one cycle are ORed per target: every named target becomes pending, and two senders naming one target give one pending bit.
- R6: A pending bit stays set until its core's clear or an accepted interrupt removes it.
- R7: A clear on core c, with no message arriving for c in that cycle, makes pending[c] 0 after the next edge and leaves the other cores unchanged.
- R8: A sync on any core has no effect on any pending or interrupt output.
- R9: irq[c] is updated at the same edge as pending[c] and equals the new pending value ANDed with enable[c] sampled at that edge.
- R10: An ack on core c while irq[c] is 1 clears pending[c] and irq[c] at the next edge. An ack while irq[c] is 0 is ignored.
- R11: A message arriving for core c in the same cycle as a clear or an accepted interrupt on c wins, and pending[c] stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | NUM_CORES | Per-core message-send strobe |
| snd_target | input | NUM_CORES*TGT_W | Per-core target field; core c uses bits [c*TGT_W +: TGT_W] |
| msg_clr | input | NUM_CORES | Per-core message-clear strobe |
| msg_sync | input | NUM_CORES | Per-core message-sync strobe (no effect) |
| hv_irq_en | input | NUM_CORES | Per-core hypervisor external-interrupt enable |
| irq_ack | input | NUM_CORES | Per-core doorbell interrupt accepted |
| db_pending | output | NUM_CORES | Per-core pending doorbell flag |
| db_irq | output | NUM_CORES | Per-core doorbell interrupt request |

## Verification
The assertions check the local rules on every cycle. These are the one-hot shape of each request vector, the out-of-range drop, pending following an arriving request, clear and acknowledge taking effect, sync leaving state alone, and the interrupt never being raised without pending and enable. Only the bench scenarios show the end-to-end behaviour across the merge stage. That covers the two-edge latency from a send to the target's pending flag, the ORing of simultaneous senders, self-targeting, and the priority of a new message over a clear or acknowledge in the same cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef struct packed {
    logic clr;
    logic sync;
    logic ack;
    logic en;
  } db_ctl_t;
endpackage

// File: rtl/db_send.sv
module db_send #(
  parameter int NUM_CORES = 4,
  parameter int TGT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic [TGT_W-1:0]     target,
  output logic [NUM_CORES-1:0] req_q
);
  logic [NUM_CORES-1:0] hit;

  generate
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_dec
      assign hit[t] = valid && (target == TGT_W'(t));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= hit;
  end

  p_req_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_q));
  p_req_cause_r2: assert property (@(posedge clk) disable iff (rst)
    valid == 1'b0 |=> req_q == '0);
  p_range_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && ({1'b0, target} >= (TGT_W+1)'(NUM_CORES))) |=> req_q == '0);
endmodule

// File: rtl/db_merge.sv
module db_merge #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES*NUM_CORES-1:0] req_all,
  output logic [NUM_CORES-1:0]           hit
);
  generate
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
      always_comb begin
        hit[t] = 1'b0;
        for (int c = 0; c < NUM_CORES; c++)
          hit[t] = hit[t] | req_all[c*NUM_CORES + t];
      end
    end
  endgenerate
endmodule

// File: rtl/db_recv.sv
module db_recv
  import doorbell_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit,
  input  db_ctl_t ctl,
  output logic    pending_q,
  output logic    irq_q
);
  logic taken;
  logic nxt;

  assign taken = ctl.ack & irq_q;
  assign nxt   = hit | (pending_q & ~ctl.clr & ~taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= nxt;
      irq_q     <= nxt & ctl.en;
    end
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    hit |=> pending_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !ctl.clr && !(ctl.ack && irq_q)) |=> pending_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr && !hit) |=> !pending_q);
  p_sync_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.sync && !hit && !ctl.clr && !(ctl.ack && irq_q)) |=> pending_q == $past(pending_q));
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pending_q);
  p_irq_en_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.en |=> !irq_q);
  p_take_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl.ack && irq_q && !hit) |=> (!pending_q && !irq_q));
  p_win_r11: assert property (@(posedge clk) disable iff (rst)
    (hit && (ctl.clr || ctl.ack)) |=> pending_q);
endmodule

// File: rtl/doorbell_hub.sv
module doorbell_hub
  import doorbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TGT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CORES-1:0]       snd_valid,
  input  logic [NUM_CORES*TGT_W-1:0] snd_target,
  input  logic [NUM_CORES-1:0]       msg_clr,
  input  logic [NUM_CORES-1:0]       msg_sync,
  input  logic [NUM_CORES-1:0]       hv_irq_en,
  input  logic [NUM_CORES-1:0]       irq_ack,
  output logic [NUM_CORES-1:0]       db_pending,
  output logic [NUM_CORES-1:0]       db_irq
);
  localparam int REQ_W = NUM_CORES * NUM_CORES;

  logic [REQ_W-1:0]     req_all;
  logic [NUM_CORES-1:0] hit;

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      db_ctl_t ctl;
      assign ctl = '{clr: msg_clr[c], sync: msg_sync[c], ack: irq_ack[c], en: hv_irq_en[c]};

      db_send #(.NUM_CORES(NUM_CORES), .TGT_W(TGT_W)) u_send (
        .clk    (clk),
        .rst    (rst),
        .valid  (snd_valid[c]),
        .target (snd_target[c*TGT_W +: TGT_W]),
        .req_q  (req_all[c*NUM_CORES +: NUM_CORES])
      );

      db_recv u_recv (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit[c]),
        .ctl       (ctl),
        .pending_q (db_pending[c]),
        .irq_q     (db_irq[c])
      );
    end
  endgenerate

  db_merge #(.NUM_CORES(NUM_CORES)) u_merge (
    .req_all (req_all),
    .hit     (hit)
  );

  p_reset_r1: assert property (@(posedge clk) rst |=> (db_pending == '0 && db_irq == '0));
endmodule

// File: tb/doorbell_hub_tb.sv
`timescale 1ns/1ps
module doorbell_hub_tb;
  localparam int N  = 4;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    snd_valid = '0;
  logic [N*TW-1:0] snd_target = '0;
  logic [N-1:0]    msg_clr = '0, msg_sync = '0, hv_irq_en = '0, irq_ack = '0;
  logic [N-1:0]    db_pending, db_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  doorbell_hub #(.NUM_CORES(N), .TGT_W(TW)) u_dut (
    .clk(clk), .rst(rst), .snd_valid(snd_valid), .snd_target(snd_target),
    .msg_clr(msg_clr), .msg_sync(msg_sync), .hv_irq_en(hv_irq_en),
    .irq_ack(irq_ack), .db_pending(db_pending), .db_irq(db_irq)
  );

  // Reference model built from the requirements
  logic [N-1:0] m_req = '0, m_pend = '0, m_irq = '0, m_nxt;

  function automatic logic [N-1:0] route(input logic [N-1:0] v, input logic [N*TW-1:0] tg);
    logic [N-1:0] r = '0;
    for (int c = 0; c < N; c++) begin
      int t = int'(tg[c*TW +: TW]);
      if (v[c] && t < N) r[t] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req <= '0; m_pend <= '0; m_irq <= '0;
    end else begin
      m_nxt = m_req | (m_pend & ~msg_clr & ~(irq_ack & m_irq));
      m_pend <= m_nxt;
      m_irq  <= m_nxt & hv_irq_en;
      m_req  <= route(snd_valid, snd_target);
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " pending"}, db_pending, m_pend);
    chk({tag, " irq"}, db_irq, m_irq);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    snd_valid = '0; msg_clr = '0; msg_sync = '0; irq_ack = '0;
  endtask

  task automatic send(input int c, input int t);
    snd_valid[c] = 1'b1;
    snd_target[c*TW +: TW] = TW'(t);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    hv_irq_en = '1;
    step(); step();
    chk("R1 reset pending", db_pending, '0);
    chk("R1 reset irq", db_irq, '0);
    rst = 1'b0;
    step();
    chk("R1 after reset", db_pending, '0);

    // R2 latency: core 0 to core 2
    send(0, 2); step(); idle();
    chk("R2 one edge, not yet", db_pending, 4'b0000);
    step();
    chk("R2 two edges", db_pending, 4'b0100);
    chk("R9 irq with enable", db_irq, 4'b0100);

    // R4 self target, R6 sticky
    send(3, 3); step(); idle(); step();
    chk("R4 self target", db_pending, 4'b1100);
    step(); step();
    chk("R6 sticky", db_pending, 4'b1100);

    // R3 out of range targets
    send(1, 9); send(2, 4); step(); idle(); step(); step();
    chk("R3 out of range", db_pending, 4'b1100);

    // R7 clear on core 2 only
    msg_clr[2] = 1'b1; step(); idle();
    chk("R7 clear local", db_pending, 4'b1000);
    chk("R7 irq follows", db_irq, 4'b1000);

    // R8 sync no effect
    msg_sync = '1; step(); step(); idle();
    chk("R8 sync pending", db_pending, 4'b1000);
    chk("R8 sync irq", db_irq, 4'b1000);

    // R9/R10: core 1 pending with enable off; ack ignored
    hv_irq_en[1] = 1'b0;
    send(0, 1); step(); idle(); step();
    chk("R9 pending no enable", db_pending, 4'b1010);
    chk("R9 irq gated", db_irq, 4'b1000);
    irq_ack[1] = 1'b1; step(); idle();
    chk("R10 ack ignored", db_pending, 4'b1010);
    // R10 accepted on core 3
    irq_ack[3] = 1'b1; step(); idle();
    chk("R10 ack taken pending", db_pending, 4'b0010);
    chk("R10 ack taken irq", db_irq, 4'b0000);
    hv_irq_en = '1; msg_clr[1] = 1'b1; step(); idle();
    chk("R7 clear core1", db_pending, 4'b0000);

    // R5 merge: cores 0,1 to 1 and core 2 to 0
    send(0, 1); send(1, 1); send(2, 0); step(); idle(); step();
    chk("R5 merge", db_pending, 4'b0011);
    chk("R5 merge irq", db_irq, 4'b0011);

    // R11: message arrives in the cycle clear and ack hit core 0 and 1
    send(3, 0); send(2, 1); step(); idle();
    msg_clr[0] = 1'b1; irq_ack[1] = 1'b1; step(); idle();
    chk("R11 message wins", db_pending, 4'b0011);
    step();
    chk("R11 stays", db_pending, 4'b0011);

    // Random phase against the model
    for (int i = 0; i < 2000; i++) begin
      for (int c = 0; c < N; c++) begin
        snd_valid[c] = ($urandom % 3) == 0;
        snd_target[c*TW +: TW] = TW'(($urandom % 4) == 0 ? $urandom % 16 : $urandom % N);
        msg_clr[c]   = ($urandom % 8) == 0;
        msg_sync[c]  = ($urandom % 4) == 0;
        irq_ack[c]   = ($urandom % 4) == 0;
        hv_irq_en[c] = ($urandom % 4) != 0;
      end
      step();
      chk_model("R2 R3 R5 R6 R7 R8 R9 R10 R11 random");
    end
    idle(); step(); step();
    chk_model("R6 settle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule